// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block drives a multichannel analog converter from a list of conversion descriptors. Software builds the list through a byte-wide register port, loads a 24-bit pacer divider, picks a pacer time base and a trigger mode, and then issues an arm command. The sequencer walks the stored descriptors from the first one onward. For each descriptor it raises a conversion request that carries the channel, gain code and differential select. It holds that request until the converter acknowledges it.

Each descriptor carries a start flag. A flagged descriptor waits for the next pacer tick. An unflagged one converts as soon as the previous conversion completes. The pacer can therefore set the spacing of single conversions (flag on every descriptor) or the spacing of whole scans (flag on the first descriptor only). In one-shot mode the sequencer makes one pass and goes idle. In continuous mode it wraps to the first descriptor. Every completed pass gives a one-cycle end-of-scan pulse, and that pulse can also be routed to an interrupt output.

A divider value of zero counts as 2^24 base periods. By default the three internal time bases are derived from a 20 MHz system clock (5 MHz, 1 MHz and 100 kHz). At the 5 MHz base one divider step is 200 ns. Software is expected to keep the pacer period at 10 µs or more.

Top module: `acq_scan_seq`

## Requirements
- R1: A descriptor is written as two byte writes to register address 0, low byte first. In the 16-bit word, bit 14 is the differential select, bits 13:12 are the gain code, bits 11:8 are the channel and bit 7 is the start flag. While a conversion is requested, these fields appear on conv_diff_o, conv_gain_o and conv_chan_o.
- R2: A descriptor whose start flag is set begins its conversion only after a pacer tick. A descriptor whose start flag is clear begins its conversion three cycles after the previous descriptor's request starts, given a converter that acknowledges in the second cycle of a request.
- R3: The pacer period is the 24-bit divider (address 3 low, 4 middle, 5 high byte) times the base period. Control register (address 1) bits 7:6 select the base: 00 is a pulse on ext_tick_i, 01 is FAST_DIV clocks, 10 is MID_DIV clocks and 11 is SLOW_DIV clocks.
- R4: Command register (address 2) bit 5 empties the descriptor list. The list holds DEPTH descriptors, and descriptors written once it is full are dropped.
- R5: Command bit 7 (arm) starts a pass at descriptor 0 when the list is not empty. Arm with an empty list leaves the block idle.
- R6: Command bit 4 (stop) returns the block to idle in the next cycle and withdraws any conversion request.
- R7: With control bit 2 clear (one-shot), the block goes idle after one full pass and pulses eos_o for exactly one cycle.
- R8: With control bit 2 set (continuous), the block wraps from the last descriptor to descriptor 0 and pulses eos_o once per pass.
- R9: irq_o pulses together with eos_o when control bit 4 is set, and it stays low when that bit is clear.
- R10: While the block is running, writes to the descriptor port and to the divider registers have no effect.
- R11: After reset, idle_o is 1, running_o is 0 and conv_req_o is 0.
- R12: A conversion request stays asserted with stable fields until conv_done_i is seen, unless a stop command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| ext_tick_i | input | 1 | External pacer pulse, one cycle per base tick |
| conv_done_i | input | 1 | Converter acknowledge for the current request |
| conv_req_o | output | 1 | Conversion request |
| conv_chan_o | output | 4 | Channel of the current descriptor |
| conv_gain_o | output | 2 | Gain code of the current descriptor |
| conv_diff_o | output | 1 | Differential select of the current descriptor |
| eos_o | output | 1 | End-of-scan pulse |
| irq_o | output | 1 | End-of-scan interrupt pulse, gated by the enable bit |
| idle_o | output | 1 | Sequencer idle |
| running_o | output | 1 | Sequencer running |

## Verification
The bench builds the block with DEPTH set to 8 and with base dividers of 1, 2 and 4 clocks. Filling the list past its capacity then takes only ten descriptors. Exact pacer intervals of 10 to 20 cycles can be measured edge to edge under every base. A 4-descriptor continuous scan completes two passes in well under a hundred cycles, so wrap order, end-of-scan counting and stop timing all fall within short directed runs. The external base is driven pulse by pulse, which shows that the divider counts base ticks rather than clocks.

// File: rtl/acq_pkg.sv
package acq_pkg;

  localparam logic [2:0] ADDR_SCAN = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_CMD  = 3'd2;
  localparam logic [2:0] ADDR_PLO  = 3'd3;
  localparam logic [2:0] ADDR_PMID = 3'd4;
  localparam logic [2:0] ADDR_PHI  = 3'd5;

  typedef struct packed {
    logic       rsv;
    logic       diff;
    logic [1:0] gain;
    logic [3:0] chan;
    logic       start;
    logic [6:0] ext;
  } entry_t;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'b00,
    SRC_FAST = 2'b01,
    SRC_MID  = 2'b10,
    SRC_SLOW = 2'b11
  } pacer_src_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEL,
    ST_WAIT,
    ST_CONV
  } seq_state_e;

endpackage

// File: rtl/acq_pacer.sv
module acq_pacer
  import acq_pkg::*;
#(
  parameter int DIV_W    = 24,
  parameter int FAST_DIV = 4,
  parameter int MID_DIV  = 20,
  parameter int SLOW_DIV = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  pacer_src_e       src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_tick_i,
  output logic             tick_o
);

  localparam int MAXD = (FAST_DIV > MID_DIV)
                      ? ((FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV)
                      : ((MID_DIV > SLOW_DIV) ? MID_DIV : SLOW_DIV);
  localparam int PW = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic [PW-1:0]    presc_q;
  logic [PW-1:0]    sel_lim;
  logic [DIV_W-1:0] cnt_q;
  logic             base_tick;
  logic [DIV_W-1:0] reload;

  always_comb begin
    case (src_i)
      SRC_FAST: sel_lim = PW'(FAST_DIV - 1);
      SRC_MID:  sel_lim = PW'(MID_DIV - 1);
      SRC_SLOW: sel_lim = PW'(SLOW_DIV - 1);
      default:  sel_lim = '0;
    endcase
  end

  assign base_tick = (src_i == SRC_EXT) ? ext_tick_i : (presc_q >= sel_lim);
  // zero wraps to all ones: 2^DIV_W base ticks
  assign reload    = div_i - DIV_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
    end else if (restart_i || !run_i || src_i == SRC_EXT) begin
      presc_q <= '0;
    end else begin
      presc_q <= base_tick ? '0 : presc_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= reload;
    end else if (run_i && base_tick) begin
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - DIV_W'(1);
    end
  end

  assign tick_o = run_i && !restart_i && base_tick && (cnt_q == '0);

endmodule

// File: rtl/acq_scan_queue.sv
module acq_scan_queue
  import acq_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          byte_we_i,
  input  logic [7:0]    byte_i,
  input  logic [IW-1:0] rd_idx_i,
  output entry_t        rd_entry_o,
  output logic [CW-1:0] count_o
);

  entry_t        mem_q [DEPTH];
  logic [7:0]    lo_q;
  logic          hi_ph_q;
  logic [CW-1:0] count_q;
  logic          push;

  assign push = byte_we_i && hi_ph_q && !clear_i && (count_q < CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_ph_q <= 1'b0;
      count_q <= '0;
    end else if (clear_i) begin
      hi_ph_q <= 1'b0;
      count_q <= '0;
    end else if (byte_we_i) begin
      if (!hi_ph_q) begin
        lo_q    <= byte_i;
        hi_ph_q <= 1'b1;
      end else begin
        hi_ph_q <= 1'b0;
        if (push) count_q <= count_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[count_q[IW-1:0]] <= entry_t'({byte_i, lo_q});
  end

  assign rd_entry_o = mem_q[rd_idx_i];
  assign count_o    = count_q;

endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_pkg::*;
#(
  parameter int IW = 11,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic          cont_i,
  input  logic [CW-1:0] count_i,
  input  logic          entry_start_i,
  input  logic          tick_i,
  input  logic          conv_done_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          restart_o,
  output logic          running_o,
  output logic          conv_req_o,
  output logic          eos_o
);

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic          pend_q;
  logic          eos_q;
  logic          last;

  assign restart_o = arm_i && !stop_i && (state_q == ST_IDLE) && (count_i != '0);
  assign last      = (CW'(idx_q) == count_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      eos_q   <= 1'b0;
    end else begin
      eos_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        pend_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (restart_o) begin
              state_q <= ST_SEL;
              idx_q   <= '0;
              pend_q  <= 1'b0;
            end
          end
          ST_SEL: begin
            if (tick_i) pend_q <= 1'b1;
            state_q <= entry_start_i ? ST_WAIT : ST_CONV;
          end
          ST_WAIT: begin
            if (tick_i || pend_q) begin
              pend_q  <= 1'b0;
              state_q <= ST_CONV;
            end
          end
          ST_CONV: begin
            if (tick_i) pend_q <= 1'b1;
            if (conv_done_i) begin
              if (last) begin
                eos_q <= 1'b1;
                idx_q <= '0;
                state_q <= cont_i ? ST_SEL : ST_IDLE;
              end else begin
                idx_q   <= idx_q + IW'(1);
                state_q <= ST_SEL;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rd_idx_o   = idx_q;
  assign running_o  = (state_q != ST_IDLE);
  assign conv_req_o = (state_q == ST_CONV);
  assign eos_o      = eos_q;

endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
  import acq_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int DIV_W    = 24,
  parameter int FAST_DIV = 4,
  parameter int MID_DIV  = 20,
  parameter int SLOW_DIV = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       ext_tick_i,
  input  logic       conv_done_i,
  output logic       conv_req_o,
  output logic [3:0] conv_chan_o,
  output logic [1:0] conv_gain_o,
  output logic       conv_diff_o,
  output logic       eos_o,
  output logic       irq_o,
  output logic       idle_o,
  output logic       running_o
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NB = (DIV_W + 7) / 8;

  pacer_src_e       src_q;
  logic             eos_en_q;
  logic             cont_q;
  logic [NB*8-1:0]  div_q;
  logic             running;
  logic             cmd_wr, arm, stop, clr, scan_we;
  logic             tick, restart, eos;
  logic [IW-1:0]    rd_idx;
  logic [CW-1:0]    count;
  entry_t           entry;

  assign cmd_wr  = wr_en_i && (wr_addr_i == ADDR_CMD);
  assign arm     = cmd_wr && wr_data_i[7];
  assign stop    = cmd_wr && wr_data_i[4];
  assign clr     = cmd_wr && wr_data_i[5] && !running;
  assign scan_we = wr_en_i && (wr_addr_i == ADDR_SCAN) && !running;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= SRC_EXT;
      eos_en_q <= 1'b0;
      cont_q   <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_CTRL) begin
      src_q    <= pacer_src_e'(wr_data_i[7:6]);
      eos_en_q <= wr_data_i[4];
      cont_q   <= wr_data_i[2];
    end
  end

  // divider bytes: one write port per byte lane
  for (genvar b = 0; b < NB; b++) begin : g_div
    localparam logic [2:0] BA = ADDR_PLO + 3'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q[b*8 +: 8] <= '0;
      end else if (wr_en_i && wr_addr_i == BA && !running) begin
        div_q[b*8 +: 8] <= wr_data_i;
      end
    end
  end

  acq_pacer #(
    .DIV_W   (DIV_W),
    .FAST_DIV(FAST_DIV),
    .MID_DIV (MID_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running),
    .restart_i (restart),
    .src_i     (src_q),
    .div_i     (div_q[DIV_W-1:0]),
    .ext_tick_i(ext_tick_i),
    .tick_o    (tick)
  );

  acq_scan_queue #(
    .DEPTH(DEPTH)
  ) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clr),
    .byte_we_i (scan_we),
    .byte_i    (wr_data_i),
    .rd_idx_i  (rd_idx),
    .rd_entry_o(entry),
    .count_o   (count)
  );

  acq_seq_fsm #(
    .IW(IW),
    .CW(CW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm),
    .stop_i       (stop),
    .cont_i       (cont_q),
    .count_i      (count),
    .entry_start_i(entry.start),
    .tick_i       (tick),
    .conv_done_i  (conv_done_i),
    .rd_idx_o     (rd_idx),
    .restart_o    (restart),
    .running_o    (running),
    .conv_req_o   (conv_req_o),
    .eos_o        (eos)
  );

  assign conv_chan_o = entry.chan;
  assign conv_gain_o = entry.gain;
  assign conv_diff_o = entry.diff;
  assign eos_o       = eos;
  assign irq_o       = eos && eos_en_q;
  assign idle_o      = !running;
  assign running_o   = running;

endmodule

// File: rtl/acq_scan_seq_chk.sv
module acq_scan_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       conv_done_i,
  input logic       conv_req_o,
  input logic [3:0] conv_chan_o,
  input logic [1:0] conv_gain_o,
  input logic       conv_diff_o,
  input logic       eos_o,
  input logic       irq_o,
  input logic       idle_o
);

  logic stop_wr, arm_wr;
  assign stop_wr = wr_en_i && wr_addr_i == 3'd2 && wr_data_i[4];
  assign arm_wr  = wr_en_i && wr_addr_i == 3'd2 && wr_data_i[7];

  // R12
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o && !conv_done_i && !stop_wr |=>
      conv_req_o && $stable(conv_chan_o) && $stable(conv_gain_o) && $stable(conv_diff_o));

  // R6
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_wr |=> idle_o && !conv_req_o);

  // R7
  eos_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);

  // R9
  irq_eos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> eos_o);

  // R5
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && !arm_wr |=> !conv_req_o);

endmodule

bind acq_scan_seq acq_scan_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .conv_done_i(conv_done_i),
  .conv_req_o (conv_req_o),
  .conv_chan_o(conv_chan_o),
  .conv_gain_o(conv_gain_o),
  .conv_diff_o(conv_diff_o),
  .eos_o      (eos_o),
  .irq_o      (irq_o),
  .idle_o     (idle_o)
);

// File: tb/acq_scan_seq_tb.sv
`timescale 1ns/1ps
module acq_scan_seq_tb;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ext_tick_i = 1'b0;
  logic       conv_done_i = 1'b0;
  logic       conv_req_o;
  logic [3:0] conv_chan_o;
  logic [1:0] conv_gain_o;
  logic       conv_diff_o;
  logic       eos_o, irq_o, idle_o, running_o;

  acq_scan_seq #(
    .DEPTH(8), .DIV_W(24), .FAST_DIV(1), .MID_DIV(2), .SLOW_DIV(4)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ext_tick_i(ext_tick_i), .conv_done_i(conv_done_i),
    .conv_req_o(conv_req_o), .conv_chan_o(conv_chan_o), .conv_gain_o(conv_gain_o),
    .conv_diff_o(conv_diff_o), .eos_o(eos_o), .irq_o(irq_o), .idle_o(idle_o),
    .running_o(running_o)
  );

  always #5 clk_i = ~clk_i;

  // converter model: acknowledge in the second cycle of a request
  always @(posedge clk_i) conv_done_i <= conv_req_o && !conv_done_i;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int n_conv = 0, n_eos = 0, n_irq = 0;
  int lg_chan [64];
  int lg_gain [64];
  int lg_diff [64];
  int lg_cyc  [64];
  logic req_d = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (conv_req_o && !req_d) begin
      if (n_conv < 64) begin
        lg_chan[n_conv] = int'(conv_chan_o);
        lg_gain[n_conv] = int'(conv_gain_o);
        lg_diff[n_conv] = int'(conv_diff_o);
        lg_cyc[n_conv]  = cyc;
      end
      n_conv++;
    end
    req_d = conv_req_o;
    if (eos_o) n_eos++;
    if (irq_o) n_irq++;
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [15:0] mk(bit diff, int gain, int chan, bit start);
    return {1'b0, diff, 2'(gain), 4'(chan), start, 7'b0};
  endfunction

  task automatic put(bit diff, int gain, int chan, bit start);
    logic [15:0] e;
    e = mk(diff, gain, chan, start);
    wr(3'd0, e[7:0]);
    wr(3'd0, e[15:8]);
  endtask

  task automatic set_div(int d);
    wr(3'd3, 8'(d));
    wr(3'd4, 8'(d >> 8));
    wr(3'd5, 8'(d >> 16));
  endtask

  task automatic wait_idle(int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk_i);
      if (idle_o) break;
    end
  endtask

  task automatic wait_eos(int target, int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk_i);
      if (n_eos >= target) break;
    end
  endtask

  task automatic t_reset();
    chk("R11", "idle after reset", int'(idle_o), 1);
    chk("R11", "running after reset", int'(running_o), 0);
    chk("R11", "request after reset", int'(conv_req_o), 0);
  endtask

  task automatic t_empty_arm();
    int b;
    b = n_conv;
    wr(3'd2, 8'h20);
    wr(3'd2, 8'h80);
    repeat (5) @(negedge clk_i);
    chk("R5", "idle after arm on empty list", int'(idle_o), 1);
    chk("R5", "conversions on empty list", n_conv - b, 0);
  endtask

  task automatic t_conv_rate();
    int b, e, q;
    b = n_conv; e = n_eos; q = n_irq;
    wr(3'd2, 8'h20);
    put(1'b0, 1, 3, 1'b1);
    put(1'b1, 2, 5, 1'b1);
    put(1'b0, 3, 9, 1'b1);
    wr(3'd1, 8'hD0);        // slow base, eos irq on, one-shot
    set_div(3);
    wr(3'd2, 8'h80);
    wait_idle(200);
    chk("R7", "one-shot conversions", n_conv - b, 3);
    chk("R1", "chan entry0", lg_chan[b], 3);
    chk("R1", "gain entry0", lg_gain[b], 1);
    chk("R1", "diff entry0", lg_diff[b], 0);
    chk("R1", "chan entry1", lg_chan[b+1], 5);
    chk("R1", "gain entry1", lg_gain[b+1], 2);
    chk("R1", "diff entry1", lg_diff[b+1], 1);
    chk("R1", "chan entry2", lg_chan[b+2], 9);
    chk("R3", "slow base period", lg_cyc[b+1] - lg_cyc[b], 12);
    chk("R2", "flagged entry waits tick", lg_cyc[b+2] - lg_cyc[b+1], 12);
    repeat (3) @(negedge clk_i);
    chk("R7", "eos pulses one-shot", n_eos - e, 1);
    chk("R9", "irq pulses when enabled", n_irq - q, 1);
    chk("R7", "idle after pass", int'(idle_o), 1);
  endtask

  task automatic t_scan_rate();
    int b, e, q;
    b = n_conv; e = n_eos; q = n_irq;
    wr(3'd2, 8'h20);
    put(1'b0, 0, 1, 1'b1);
    put(1'b0, 0, 2, 1'b0);
    put(1'b0, 0, 3, 1'b0);
    put(1'b0, 0, 4, 1'b0);
    wr(3'd1, 8'h44);        // fast base, irq off, continuous
    set_div(20);
    wr(3'd2, 8'h80);
    wait_eos(e + 2, 300);
    wr(3'd2, 8'h10);
    chk("R6", "idle after stop", int'(idle_o), 1);
    chk("R6", "request withdrawn", int'(conv_req_o), 0);
    repeat (40) @(negedge clk_i);
    chk("R8", "conversions in two passes", n_conv - b, 8);
    for (int k = 0; k < 8; k++) chk("R8", "wrap order", lg_chan[b+k], (k % 4) + 1);
    chk("R2", "unflagged entry follows", lg_cyc[b+1] - lg_cyc[b], 3);
    chk("R3", "fast base scan period", lg_cyc[b+4] - lg_cyc[b], 20);
    chk("R8", "eos per pass", n_eos - e, 2);
    chk("R9", "irq disabled", n_irq - q, 0);
  endtask

  task automatic t_ignore_running();
    int b, e;
    b = n_conv; e = n_eos;
    wr(3'd2, 8'h80);
    put(1'b0, 0, 15, 1'b1);
    wr(3'd3, 8'h05);
    wait_eos(e + 2, 300);
    wr(3'd2, 8'h10);
    repeat (40) @(negedge clk_i);
    chk("R10", "conversions unchanged list", n_conv - b, 8);
    chk("R10", "last entry still chan4", lg_chan[b+7], 4);
    chk("R10", "divider unchanged", lg_cyc[b+4] - lg_cyc[b], 20);
  endtask

  task automatic pulse_ext();
    @(negedge clk_i); ext_tick_i = 1'b1;
    @(negedge clk_i); ext_tick_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_ext();
    int b;
    b = n_conv;
    wr(3'd2, 8'h20);
    put(1'b0, 0, 6, 1'b1);
    put(1'b0, 0, 7, 1'b1);
    wr(3'd1, 8'h00);        // external base, one-shot
    set_div(2);
    wr(3'd2, 8'h80);
    repeat (20) @(negedge clk_i);
    chk("R3", "no conversion without ext pulses", n_conv - b, 0);
    pulse_ext();
    chk("R3", "one ext pulse, divider 2", n_conv - b, 0);
    pulse_ext();
    chk("R3", "two ext pulses", n_conv - b, 1);
    pulse_ext();
    pulse_ext();
    chk("R3", "four ext pulses", n_conv - b, 2);
    chk("R3", "ext chan", lg_chan[b+1], 7);
    chk("R7", "idle after ext pass", int'(idle_o), 1);
  endtask

  task automatic t_mid();
    int b;
    b = n_conv;
    wr(3'd1, 8'h80);        // mid base, one-shot
    set_div(5);
    wr(3'd2, 8'h80);
    wait_idle(200);
    chk("R3", "mid base conversions", n_conv - b, 2);
    chk("R3", "mid base period", lg_cyc[b+1] - lg_cyc[b], 10);
  endtask

  task automatic t_full();
    int b;
    b = n_conv;
    wr(3'd2, 8'h20);
    for (int k = 0; k < 10; k++) put(1'b0, 0, k, 1'b0);
    wr(3'd1, 8'h40);
    wr(3'd2, 8'h80);
    wait_idle(200);
    chk("R4", "capacity limits list", n_conv - b, 8);
    chk("R4", "last kept entry", lg_chan[b+7], 7);
    chk("R4", "first entry", lg_chan[b], 0);
    b = n_conv;
    wr(3'd2, 8'h20);
    wr(3'd2, 8'h80);
    repeat (6) @(negedge clk_i);
    chk("R4", "cleared list gives no conversion", n_conv - b, 0);
    chk("R5", "arm after clear stays idle", int'(idle_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_empty_arm();
    t_conv_rate();
    t_scan_rate();
    t_ignore_running();
    t_ext();
    t_mid();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule